// File: doc/BRIEF.md
# Focus Search and Lock Sequencer

This block hunts for focus on an optical pickup. A search command resets a digital actuator drive code to midscale and then walks it one code per ramp tick, a tick being a fixed number of clock cycles. Two comparator inputs, built outside the block from the focus error signal, tell it when the error has risen past the reference plus a threshold and when it has come back to the reference. Only that ordered pair counts as a valid zero crossing. When one is seen, the drive code freezes, the servo loop mute is released and a lock flag rises.

A strap-style mode input, sampled when a search begins, picks one of two sweeps. The bipolar sweep goes from midscale down to zero, up to full scale, then back to midscale. The positive-only sweep goes from midscale up to full scale and back to midscale. If a sweep ends with no valid crossing, a timeout flag rises, the code sits at midscale and the loop stays muted. Separate servo-on and servo-off commands release or force the mute outside a search. Analog smoothing and summing of the drive are left to the surrounding circuit.

Top module: `focus_search_seq`

## Requirements
- R1: While reset is held and right after it, ramp_code is midscale (2^(CODE_W-1)), loop_mute is 1, focus_lock is 0 and search_timeout is 0.
- R2: A search_cmd pulse reloads midscale, sets loop_mute, clears focus_lock and search_timeout, and from then on ramp_code moves by exactly one code at the end of every TICK_DIV clock cycles.
- R3: With pos_only = 0 at the start, the code steps down from midscale to 0, then up to 2^CODE_W-1, then down to midscale, which takes 2*(2^CODE_W-1) ticks.
- R4: With pos_only = 1 at the start, the code steps up from midscale to 2^CODE_W-1 and then down to midscale, never going below midscale, which takes 2*(2^(CODE_W-1)-1) ticks.
- R5: A crossing is valid only if cmp_above has been high in some cycle of the current search before cmp_at_ref is high; cmp_at_ref with no earlier cmp_above in that search is ignored.
- R6: On a valid crossing, focus_lock becomes 1 and loop_mute becomes 0 one clock later, and ramp_code holds its value from then on.
- R7: When a sweep returns to midscale with no valid crossing, search_timeout becomes 1 in the same cycle, ramp_code is midscale, loop_mute stays 1 and focus_lock stays 0.
- R8: servo_on_cmd outside a search clears loop_mute while focus_lock stays 0; during a search it is ignored and loop_mute stays 1.
- R9: servo_off_cmd sets loop_mute, clears focus_lock, reloads midscale and ends any search; it takes priority over a search_cmd in the same cycle.
- R10: pos_only is sampled only at the start of a search; a change during a sweep does not alter it.
- R11: The comparator inputs have no effect outside a search: focus_lock stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| search_cmd | input | 1 | One-cycle pulse that starts a focus search |
| servo_on_cmd | input | 1 | One-cycle pulse that releases the loop mute when idle |
| servo_off_cmd | input | 1 | One-cycle pulse that mutes the loop and aborts a search |
| pos_only | input | 1 | Sweep mode: 1 positive-only, 0 bipolar |
| cmp_above | input | 1 | Focus error above reference plus threshold |
| cmp_at_ref | input | 1 | Focus error back at reference |
| ramp_code | output | CODE_W | Actuator drive code, midscale is the rest position |
| loop_mute | output | 1 | 1 while the focus loop compensation is muted |
| focus_lock | output | 1 | 1 once focus is found |
| search_timeout | output | 1 | 1 when the last sweep ended without focus |

## Verification
On every cycle the assertions check that the code never moves by more than one step except when midscale is reloaded, that a positive-only sweep never goes below midscale, that the ticks are spaced apart, that a lock edge is preceded by an armed detector and the return comparator, that a locked code stays frozen, that a timeout leaves the code at midscale with the loop muted, and that a servo-off always mutes. The exact sweep shapes and lengths, the order of the two comparator events, and the mode being ignored in the middle of a sweep can only be shown by the bench's scenarios. The bench compares every tick of both full sweeps with arithmetic values, and it also checks the command priorities.

// File: rtl/fss_pkg.sv
package fss_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SERVO  = 2'd1,
      SEQ_SEARCH = 2'd2,
      SEQ_LOCKED = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      LEG_STOP      = 2'd0,
      LEG_FALL_LOW  = 2'd1,
      LEG_RISE      = 2'd2,
      LEG_FALL_HOME = 2'd3
   } ramp_leg_t;

endpackage

// File: rtl/fss_tick_gen.sv
module fss_tick_gen #(
   parameter int TICK_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("fss_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every_cycle
      assign tick = run;
   end else begin : g_divider
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (clear || !run) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = run && (cnt == LAST);

      // R2: two ticks are never back to back when the divider is active
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

endmodule

// File: rtl/fss_ramp_gen.sv
module fss_ramp_gen
   import fss_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              step,
   input  logic              pos_mode,
   output logic [CODE_W-1:0] code,
   output logic              sweep_done
);

   localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] TOP  = '1;
   localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

   ramp_leg_t leg;
   logic      pos_flag;

   always_comb begin
      sweep_done = step && (leg == LEG_FALL_HOME) && (code == MID + ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code     <= MID;
         leg      <= LEG_STOP;
         pos_flag <= 1'b0;
      end else if (start) begin
         code     <= MID;
         pos_flag <= pos_mode;
         leg      <= pos_mode ? LEG_RISE : LEG_FALL_LOW;
      end else if (abort) begin
         code <= MID;
         leg  <= LEG_STOP;
      end else if (step) begin
         case (leg)
            LEG_FALL_LOW: begin
               code <= code - ONE;
               if (code == ONE) leg <= LEG_RISE;
            end
            LEG_RISE: begin
               code <= code + ONE;
               if (code == TOP - ONE) leg <= LEG_FALL_HOME;
            end
            LEG_FALL_HOME: begin
               code <= code - ONE;
               if (code == MID + ONE) leg <= LEG_STOP;
            end
            default: begin
               code <= code;
            end
         endcase
      end
   end

   // R2: outside a reload the code moves by at most one step per cycle
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && !$past(abort)) |->
         ((code == $past(code)) || (code == $past(code) + ONE) ||
          (code == $past(code) - ONE)));

   // R4: a positive-only sweep stays at or above midscale
   a_r4_pos_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_flag && (leg != LEG_STOP)) |-> (code >= MID));

endmodule

// File: rtl/fss_zc_detect.sv
module fss_zc_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic enable,
   input  logic above,
   input  logic at_ref,
   output logic armed,
   output logic hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (clear) begin
         armed <= 1'b0;
      end else if (enable && above) begin
         armed <= 1'b1;
      end
   end

   assign hit = enable && armed && at_ref;

endmodule

// File: rtl/focus_search_seq.sv
module focus_search_seq
   import fss_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int TICK_DIV = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              search_cmd,
   input  logic              servo_on_cmd,
   input  logic              servo_off_cmd,
   input  logic              pos_only,
   input  logic              cmp_above,
   input  logic              cmp_at_ref,
   output logic [CODE_W-1:0] ramp_code,
   output logic              loop_mute,
   output logic              focus_lock,
   output logic              search_timeout
);

   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   if (CODE_W < 2) begin : g_bad_width
      $error("focus_search_seq: CODE_W must be at least 2");
   end

   seq_state_t state, state_nx;
   logic       start_go;
   logic       abort_go;
   logic       searching;
   logic       tick;
   logic       zc_armed;
   logic       zc_hit;
   logic       sweep_done;
   logic       timeout_q;

   assign abort_go  = servo_off_cmd;
   assign start_go  = search_cmd && !servo_off_cmd;
   assign searching = (state == SEQ_SEARCH);

   fss_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_go),
      .run   (searching),
      .tick  (tick)
   );

   fss_ramp_gen #(
      .CODE_W (CODE_W)
   ) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_go),
      .abort      (abort_go),
      .step       (tick && !zc_hit),
      .pos_mode   (pos_only),
      .code       (ramp_code),
      .sweep_done (sweep_done)
   );

   fss_zc_detect u_zc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_go),
      .enable (searching),
      .above  (cmp_above),
      .at_ref (cmp_at_ref),
      .armed  (zc_armed),
      .hit    (zc_hit)
   );

   always_comb begin
      state_nx = state;
      if (abort_go) begin
         state_nx = SEQ_IDLE;
      end else if (start_go) begin
         state_nx = SEQ_SEARCH;
      end else begin
         case (state)
            SEQ_IDLE:   if (servo_on_cmd) state_nx = SEQ_SERVO;
            SEQ_SEARCH: begin
               if (zc_hit)          state_nx = SEQ_LOCKED;
               else if (sweep_done) state_nx = SEQ_IDLE;
            end
            default:    state_nx = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         timeout_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (start_go) begin
            timeout_q <= 1'b0;
         end else if (searching && !abort_go && sweep_done && !zc_hit) begin
            timeout_q <= 1'b1;
         end
      end
   end

   assign loop_mute      = (state == SEQ_IDLE) || (state == SEQ_SEARCH);
   assign focus_lock     = (state == SEQ_LOCKED);
   assign search_timeout = timeout_q;

   // R6: a lock edge needs an armed detector and the return comparator
   a_r6_lock_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(focus_lock) |-> ($past(zc_armed) && $past(cmp_at_ref)));

   // R6: a held lock freezes the drive code
   a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (focus_lock && $past(focus_lock)) |-> $stable(ramp_code));

   // R7: a timeout leaves the code home and the loop muted
   a_r7_timeout_home: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(search_timeout) |-> ((ramp_code == MID) && loop_mute && !focus_lock));

   // R9: servo off always mutes, unlocks and homes the code
   a_r9_off_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(servo_off_cmd) |-> (loop_mute && !focus_lock && (ramp_code == MID)));

   // R8: a search start keeps the loop muted whatever servo-on does
   a_r8_search_muted: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(search_cmd) && !$past(servo_off_cmd)) |-> (loop_mute && !focus_lock));

endmodule

// File: tb/focus_search_seq_tb.sv
`timescale 1ns/1ps
module focus_search_seq_tb;

   localparam int W   = 6;
   localparam int DIV = 3;
   localparam int MID = 1 << (W - 1);
   localparam int TOP = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         search_cmd = 1'b0;
   logic         servo_on_cmd = 1'b0;
   logic         servo_off_cmd = 1'b0;
   logic         pos_only = 1'b0;
   logic         cmp_above = 1'b0;
   logic         cmp_at_ref = 1'b0;
   logic [W-1:0] ramp_code;
   logic         loop_mute;
   logic         focus_lock;
   logic         search_timeout;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   focus_search_seq #(
      .CODE_W   (W),
      .TICK_DIV (DIV)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .search_cmd     (search_cmd),
      .servo_on_cmd   (servo_on_cmd),
      .servo_off_cmd  (servo_off_cmd),
      .pos_only       (pos_only),
      .cmp_above      (cmp_above),
      .cmp_at_ref     (cmp_at_ref),
      .ramp_code      (ramp_code),
      .loop_mute      (loop_mute),
      .focus_lock     (focus_lock),
      .search_timeout (search_timeout)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_code(input int k, input bit pos);
      if (pos) begin
         if (k <= TOP - MID) return MID + k;
         return TOP - (k - (TOP - MID));
      end
      if (k <= MID) return MID - k;
      if (k <= MID + TOP) return k - MID;
      return TOP - (k - MID - TOP);
   endfunction

   // bit0 search, bit1 servo on, bit2 servo off
   task automatic pulse(input int mask);
      @(negedge clk);
      search_cmd    = mask[0];
      servo_on_cmd  = mask[1];
      servo_off_cmd = mask[2];
      @(negedge clk);
      search_cmd    = 1'b0;
      servo_on_cmd  = 1'b0;
      servo_off_cmd = 1'b0;
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * DIV) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sweep(input bit pos, input bit flip, input string tag);
      int total;
      total = pos ? 2 * (TOP - MID) : 2 * TOP;
      pos_only = pos;
      pulse(1);
      chk({tag, " R2 start mute"}, int'(loop_mute), 1);
      chk({tag, " R2 start code"}, int'(ramp_code), MID);
      chk({tag, " R2 timeout cleared"}, int'(search_timeout), 0);
      for (int k = 1; k <= total; k++) begin
         wait_ticks(1);
         if (flip && k == 3) pos_only = ~pos;   // R10: mid-sweep change
         chk({tag, " R3/R4/R10 code"}, int'(ramp_code), exp_code(k, pos));
         if (k < total) chk({tag, " R7 no early timeout"}, int'(search_timeout), 0);
      end
      chk({tag, " R7 timeout"}, int'(search_timeout), 1);
      chk({tag, " R7 muted"}, int'(loop_mute), 1);
      chk({tag, " R7 unlocked"}, int'(focus_lock), 0);
      wait_ticks(2);
      chk({tag, " R7 code home"}, int'(ramp_code), MID);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset code", int'(ramp_code), MID);
      chk("R1 reset mute", int'(loop_mute), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 lock after reset", int'(focus_lock), 0);
      chk("R1 timeout after reset", int'(search_timeout), 0);

      // R11: comparators outside a search
      @(negedge clk); cmp_above = 1'b1;
      @(negedge clk); cmp_above = 1'b0; cmp_at_ref = 1'b1;
      @(negedge clk); cmp_at_ref = 1'b0;
      @(negedge clk);
      chk("R11 idle lock", int'(focus_lock), 0);
      chk("R11 idle mute", int'(loop_mute), 1);

      // R8: servo on while idle
      pulse(2);
      chk("R8 servo on unmutes", int'(loop_mute), 0);
      chk("R8 servo on no lock", int'(focus_lock), 0);

      sweep(1'b0, 1'b0, "bipolar");
      sweep(1'b1, 1'b1, "positive");

      // R5/R6: ordered crossing
      pos_only = 1'b0;
      pulse(1);
      wait_ticks(4);
      @(negedge clk); cmp_at_ref = 1'b1;
      @(negedge clk); cmp_at_ref = 1'b0;
      @(negedge clk);
      chk("R5 return alone ignored", int'(focus_lock), 0);
      chk("R5 still muted", int'(loop_mute), 1);
      @(negedge clk); cmp_above = 1'b1;
      @(negedge clk); cmp_above = 1'b0; cmp_at_ref = 1'b1;
      @(negedge clk); cmp_at_ref = 1'b0;
      chk("R6 lock", int'(focus_lock), 1);
      chk("R6 unmuted", int'(loop_mute), 0);
      held = int'(ramp_code);
      chk("R6 code in first leg", int'(held >= MID - 8 && held <= MID - 4), 1);
      pulse(2);
      repeat (5 * DIV) @(posedge clk);
      @(negedge clk);
      chk("R6 code held", int'(ramp_code), held);
      chk("R6 lock held", int'(focus_lock), 1);

      // R9: servo off from lock
      pulse(4);
      chk("R9 off unlocks", int'(focus_lock), 0);
      chk("R9 off mutes", int'(loop_mute), 1);
      chk("R9 off homes", int'(ramp_code), MID);

      // R8 ignored during search, then R9 abort
      pulse(1);
      wait_ticks(2);
      pulse(2);
      chk("R8 ignored in search", int'(loop_mute), 1);
      pulse(4);
      chk("R9 abort homes", int'(ramp_code), MID);
      wait_ticks(3);
      chk("R9 abort stays home", int'(ramp_code), MID);
      chk("R9 abort no timeout", int'(search_timeout), 0);
      chk("R9 abort muted", int'(loop_mute), 1);

      // R9 priority over search
      pulse(1);
      wait_ticks(2);
      pulse(5);
      wait_ticks(3);
      chk("R9 priority code", int'(ramp_code), MID);
      chk("R9 priority mute", int'(loop_mute), 1);
      chk("R9 priority no lock", int'(focus_lock), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule